// File: doc/BRIEF.md
# Flag-Generating Arithmetic and Logic Unit

This block is the integer datapath slice of a processor execution stage. It accepts one operation per clock, qualified by `op_valid`, on either 8-bit or 16-bit operands (chosen per operation by `wide`). The unit covers four groups of operations:

- Arithmetic: add, add with carry, subtract, subtract with borrow, increment, decrement, negate and compare.
- Bitwise: AND, OR, XOR, NOT and test.
- One-position shifts: left, logical right and arithmetic right.
- One-position rotates: within the operand, or through the carry flag.

It also has three carry-only operations: set, clear and complement.

The result and a six-bit status word are registered. Both appear on the outputs on the clock edge that follows the accepted operation. The status word holds carry, auxiliary (nibble) carry, parity, zero, sign and overflow. Each operation group updates only its own subset of these flags, and the other flags keep their values. Compare and test set the flags but write no result. `res_we` is high for one cycle when a new result has been written into `res_out`. Between operations, `res_out` holds the last written result.

Top module: `flg_alu_core`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears `res_out`, `res_we` and `flags_out`. The status word has these bit positions: bit0 carry, bit1 auxiliary, bit2 parity, bit3 zero, bit4 sign, bit5 overflow.
- R2: An operation accepted on a clock edge with `op_valid` high appears on `res_out`, `flags_out` and `res_we` after that same edge. `res_we` is high in that cycle only for operations that write a result. With `op_valid` low, all outputs hold and `res_we` is 0.
- R3: Add group. ADD (code 0), ADC (code 1, which adds the current carry) and INC (code 4, which adds one) produce the sum and set carry to the carry out of the operand's top bit. Overflow is set when both operands have the same sign and the result's sign differs from it. INC leaves carry unchanged.
- R4: Subtract group. SUB (code 2), SBB (code 3, which also subtracts the current carry), DEC (code 5, which subtracts one) and NEG (code 6, which computes zero minus A) set carry on a borrow. For NEG this means carry is set when A is nonzero. Overflow is set when the operand signs differ and the result's sign differs from the sign of the minuend. DEC leaves carry unchanged.
- R5: For every add and subtract group operation, the auxiliary flag is the carry or borrow between bit 3 and bit 4.
- R6: When an operation updates parity, the parity flag is 1 exactly when the low 8 bits of the result hold an even number of ones. This holds in both widths.
- R7: When an operation updates them, the zero flag is 1 exactly when the result is zero, and the sign flag equals the result's top bit for the selected width.
- R8: With `wide` = 0, only bits 7:0 of the operands are used. Bits 15:8 of the result are 0, and carry, sign and overflow are taken at bit 7.
- R9: AND (code 8), OR (code 9) and XOR (code 10) write the bitwise result and clear carry, overflow and auxiliary. NOT (code 11) writes the complement of A and leaves every flag unchanged.
- R10: CMP (code 7) sets the flags exactly as SUB would, and TEST (code 12) sets them exactly as AND would. Neither operation writes `res_out` nor raises `res_we`.
- R11: Shifts by one position. SHL (code 13) fills the vacated bit with 0 and puts the old top bit in carry. SHR (code 14) fills the top with 0. SAR (code 15) refills the top with the old top bit. Both right shifts put the old bit 0 in carry. Overflow is as follows: result top bit XOR carry for SHL, old top bit for SHR, and 0 for SAR. Shifts update parity, zero and sign, and clear auxiliary.
- R12: Rotates by one position. ROL (code 16) and ROR (code 17) rotate within the operand and copy the wrapped bit to carry. RCL (code 18) shifts the top bit into carry and the old carry into bit 0. RCR (code 19) shifts bit 0 into carry and the old carry into the top bit. Overflow is result top bit XOR carry for the left rotates, and the XOR of the two top result bits for the right rotates. Auxiliary, parity, zero and sign are unchanged.
- R13: STC (code 20), CLC (code 21) and CMC (code 22) set, clear or invert the carry flag. They leave the other flags and `res_out` unchanged.
- R14: Operation codes 23 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept the operation on this edge |
| op_code | input | 5 | Operation select (codes as listed in the requirements) |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand (destination or minuend) |
| opnd_b | input | 16 | Second operand |
| res_out | output | 16 | Last written result |
| res_we | output | 1 | High for the cycle in which a new result is written |
| flags_out | output | 6 | Status word {overflow, sign, zero, parity, auxiliary, carry} |

## Verification
Every result, flag and write strobe is due exactly one rising edge after the cycle in which `op_valid` is high. The bench applies each operation at a falling edge and holds it for one full cycle. It then removes it and samples all three outputs at the next falling edge. For writing operations, it samples `res_we` once more one cycle later to confirm that the strobe has dropped. Carry-dependent operations (ADC, SBB, RCL, RCR, CMC) depend on the flag state left by the vectors before them. The vector order is therefore part of the expected values.

// File: rtl/flg_alu_pkg.sv
package flg_alu_pkg;

    localparam int PAR_W = 8;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_INC  = 5'd4,
        OP_DEC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_CMP  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_NOT  = 5'd11,
        OP_TEST = 5'd12,
        OP_SHL  = 5'd13,
        OP_SHR  = 5'd14,
        OP_SAR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_RCL  = 5'd18,
        OP_RCR  = 5'd19,
        OP_STC  = 5'd20,
        OP_CLC  = 5'd21,
        OP_CMC  = 5'd22
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_NONE,
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_SHIFT
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOT
    } logic_e;

    typedef enum logic [2:0] {
        SK_SHL,
        SK_SHR,
        SK_SAR,
        SK_ROL,
        SK_ROR,
        SK_RCL,
        SK_RCR
    } shift_e;

    typedef enum logic [1:0] {
        CC_KEEP,
        CC_SET,
        CC_CLR,
        CC_FLIP
    } carry_ctl_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic aux;
        logic cry;
    } flag_t;

    localparam logic [5:0] UPD_ALL  = 6'b111111;
    localparam logic [5:0] UPD_NOC  = 6'b111110;
    localparam logic [5:0] UPD_CO   = 6'b100001;
    localparam logic [5:0] UPD_C    = 6'b000001;
    localparam logic [5:0] UPD_NONE = 6'b000000;

endpackage

// File: rtl/flg_add_sub.sv
module flg_add_sub #(
    parameter int W = 16
) (
    input  logic         wide,
    input  logic         do_sub,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res,
    output logic         cry,
    output logic         aux,
    output logic         ovf
);
    localparam int HALF_W = W / 2;

    logic [W:0] sum;
    logic       xm, ym, rm;

    always_comb begin
        if (do_sub) begin
            sum = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
        end else begin
            sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        end
    end

    assign res = sum[W-1:0] & mask;
    assign cry = wide ? sum[W] : sum[HALF_W];
    assign aux = x[4] ^ y[4] ^ sum[4];
    assign xm  = wide ? x[W-1] : x[HALF_W-1];
    assign ym  = wide ? y[W-1] : y[HALF_W-1];
    assign rm  = wide ? res[W-1] : res[HALF_W-1];

    always_comb begin
        if (do_sub) begin
            ovf = (xm != ym) && (rm != xm);
        end else begin
            ovf = (xm == ym) && (rm != xm);
        end
    end

endmodule

// File: rtl/flg_shift_rot.sv
module flg_shift_rot
    import flg_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         wide,
    input  shift_e       kind,
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res,
    output logic         cry,
    output logic         ovf
);
    localparam int HALF_W = W / 2;
    localparam logic [W-1:0] TOP_FULL = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] TOP_HALF = {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

    logic [W-1:0] left, right, top_one;
    logic         old_top, new_top, new_next;

    assign top_one = wide ? TOP_FULL : TOP_HALF;
    assign old_top = wide ? a[W-1] : a[HALF_W-1];
    assign left    = (a << 1) & mask;
    assign right   = a >> 1;

    always_comb begin
        res = left;
        cry = old_top;
        unique case (kind)
            SK_SHL: begin res = left;                                cry = old_top; end
            SK_SHR: begin res = right;                               cry = a[0];    end
            SK_SAR: begin res = right | (old_top ? top_one : '0);    cry = a[0];    end
            SK_ROL: begin res = left | {{(W-1){1'b0}}, old_top};     cry = old_top; end
            SK_ROR: begin res = right | (a[0] ? top_one : '0);       cry = a[0];    end
            SK_RCL: begin res = left | {{(W-1){1'b0}}, cin};         cry = old_top; end
            SK_RCR: begin res = right | (cin ? top_one : '0);        cry = a[0];    end
            default: begin res = left;                               cry = old_top; end
        endcase
    end

    assign new_top  = wide ? res[W-1] : res[HALF_W-1];
    assign new_next = wide ? res[W-2] : res[HALF_W-2];

    always_comb begin
        unique case (kind)
            SK_SHL, SK_ROL, SK_RCL: ovf = new_top ^ cry;
            SK_SHR:                 ovf = old_top;
            SK_SAR:                 ovf = 1'b0;
            SK_ROR, SK_RCR:         ovf = new_top ^ new_next;
            default:                ovf = 1'b0;
        endcase
    end

endmodule

// File: rtl/flg_status_eval.sv
module flg_status_eval
    import flg_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         wide,
    input  logic [W-1:0] res,
    output logic         par,
    output logic         zro,
    output logic         sgn
);
    localparam int HALF_W = W / 2;

    assign par = ~^res[PAR_W-1:0];
    assign zro = (res == '0);
    assign sgn = wide ? res[W-1] : res[HALF_W-1];

endmodule

// File: rtl/flg_alu_core.sv
module flg_alu_core
    import flg_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic              wide,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_out,
    output logic              res_we,
    output logic [5:0]        flags_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] MASK_FULL = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] MASK_HALF = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE_W     = {{(DATA_W-1){1'b0}}, 1'b1};

    alu_op_e             op_e;
    unit_e               d_unit;
    logic_e              d_lop;
    shift_e              d_shk;
    carry_ctl_e          d_cc;
    logic                d_sub, d_yone, d_xzero, d_cin_cf, d_wr;
    logic [5:0]          d_mask;

    logic [DATA_W-1:0]   wmask, a_m, b_m, x_in, y_in;
    logic [DATA_W-1:0]   as_res, sh_res, lg_res, res_sel;
    logic                as_cry, as_aux, as_ovf, sh_cry, sh_ovf;
    logic                ev_par, ev_zro, ev_sgn;

    flag_t               flags_q, flag_new;
    logic [5:0]          flags_d;
    logic [DATA_W-1:0]   res_q;
    logic                we_q;

    assign op_e  = alu_op_e'(op_code);
    assign wmask = wide ? MASK_FULL : MASK_HALF;
    assign a_m   = opnd_a & wmask;
    assign b_m   = opnd_b & wmask;

    // Decode: which unit, how the operands feed it, what is written back
    always_comb begin
        d_unit   = UNIT_NONE;
        d_lop    = LG_AND;
        d_shk    = SK_SHL;
        d_cc     = CC_KEEP;
        d_sub    = 1'b0;
        d_yone   = 1'b0;
        d_xzero  = 1'b0;
        d_cin_cf = 1'b0;
        d_wr     = 1'b0;
        d_mask   = UPD_NONE;
        unique case (op_e)
            OP_ADD:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_ALL; end
            OP_ADC:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_ALL; d_cin_cf = 1'b1; end
            OP_SUB:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_ALL; d_sub = 1'b1; end
            OP_SBB:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_ALL; d_sub = 1'b1; d_cin_cf = 1'b1; end
            OP_INC:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_NOC; d_yone = 1'b1; end
            OP_DEC:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_NOC; d_yone = 1'b1; d_sub = 1'b1; end
            OP_NEG:  begin d_unit = UNIT_ARITH; d_wr = 1'b1; d_mask = UPD_ALL; d_xzero = 1'b1; d_sub = 1'b1; end
            OP_CMP:  begin d_unit = UNIT_ARITH; d_mask = UPD_ALL; d_sub = 1'b1; end
            OP_AND:  begin d_unit = UNIT_LOGIC; d_wr = 1'b1; d_mask = UPD_ALL; d_lop = LG_AND; end
            OP_OR:   begin d_unit = UNIT_LOGIC; d_wr = 1'b1; d_mask = UPD_ALL; d_lop = LG_OR; end
            OP_XOR:  begin d_unit = UNIT_LOGIC; d_wr = 1'b1; d_mask = UPD_ALL; d_lop = LG_XOR; end
            OP_NOT:  begin d_unit = UNIT_LOGIC; d_wr = 1'b1; d_mask = UPD_NONE; d_lop = LG_NOT; end
            OP_TEST: begin d_unit = UNIT_LOGIC; d_mask = UPD_ALL; d_lop = LG_AND; end
            OP_SHL:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_ALL; d_shk = SK_SHL; end
            OP_SHR:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_ALL; d_shk = SK_SHR; end
            OP_SAR:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_ALL; d_shk = SK_SAR; end
            OP_ROL:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_CO;  d_shk = SK_ROL; end
            OP_ROR:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_CO;  d_shk = SK_ROR; end
            OP_RCL:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_CO;  d_shk = SK_RCL; end
            OP_RCR:  begin d_unit = UNIT_SHIFT; d_wr = 1'b1; d_mask = UPD_CO;  d_shk = SK_RCR; end
            OP_STC:  begin d_mask = UPD_C; d_cc = CC_SET;  end
            OP_CLC:  begin d_mask = UPD_C; d_cc = CC_CLR;  end
            OP_CMC:  begin d_mask = UPD_C; d_cc = CC_FLIP; end
            default: begin d_mask = UPD_NONE; end
        endcase
    end

    assign x_in = d_xzero ? '0 : a_m;
    assign y_in = d_xzero ? a_m : (d_yone ? ONE_W : b_m);

    flg_add_sub #(.W(DATA_W)) u_add_sub (
        .wide   (wide),
        .do_sub (d_sub),
        .x      (x_in),
        .y      (y_in),
        .cin    (d_cin_cf & flags_q.cry),
        .mask   (wmask),
        .res    (as_res),
        .cry    (as_cry),
        .aux    (as_aux),
        .ovf    (as_ovf)
    );

    flg_shift_rot #(.W(DATA_W)) u_shift_rot (
        .wide (wide),
        .kind (d_shk),
        .a    (a_m),
        .cin  (flags_q.cry),
        .mask (wmask),
        .res  (sh_res),
        .cry  (sh_cry),
        .ovf  (sh_ovf)
    );

    always_comb begin
        unique case (d_lop)
            LG_AND:  lg_res = a_m & b_m;
            LG_OR:   lg_res = a_m | b_m;
            LG_XOR:  lg_res = a_m ^ b_m;
            LG_NOT:  lg_res = ~a_m & wmask;
            default: lg_res = a_m & b_m;
        endcase
    end

    always_comb begin
        unique case (d_unit)
            UNIT_ARITH: res_sel = as_res;
            UNIT_LOGIC: res_sel = lg_res;
            UNIT_SHIFT: res_sel = sh_res;
            default:    res_sel = res_q;
        endcase
    end

    flg_status_eval #(.W(DATA_W)) u_status_eval (
        .wide (wide),
        .res  (res_sel),
        .par  (ev_par),
        .zro  (ev_zro),
        .sgn  (ev_sgn)
    );

    // Candidate flag values per unit, then merge through the update mask
    always_comb begin
        flag_new     = flags_q;
        flag_new.par = ev_par;
        flag_new.zro = ev_zro;
        flag_new.sgn = ev_sgn;
        unique case (d_unit)
            UNIT_ARITH: begin
                flag_new.cry = as_cry;
                flag_new.aux = as_aux;
                flag_new.ovf = as_ovf;
            end
            UNIT_LOGIC: begin
                flag_new.cry = 1'b0;
                flag_new.aux = 1'b0;
                flag_new.ovf = 1'b0;
            end
            UNIT_SHIFT: begin
                flag_new.cry = sh_cry;
                flag_new.aux = 1'b0;
                flag_new.ovf = sh_ovf;
            end
            default: begin
                flag_new = flags_q;
            end
        endcase
        unique case (d_cc)
            CC_SET:  flag_new.cry = 1'b1;
            CC_CLR:  flag_new.cry = 1'b0;
            CC_FLIP: flag_new.cry = ~flags_q.cry;
            default: ;
        endcase
    end

    assign flags_d = (flag_new & d_mask) | (flags_q & ~d_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            res_q   <= '0;
            we_q    <= 1'b0;
        end else begin
            we_q <= op_valid && d_wr;
            if (op_valid) begin
                flags_q <= flags_d;
                if (d_wr) begin
                    res_q <= res_sel;
                end
            end
        end
    end

    assign res_out   = res_q;
    assign res_we    = we_q;
    assign flags_out = flags_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> ($stable(res_out) && $stable(flags_out) && !res_we)) else $error("idle changed state"); // R2
    AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && (op_e == OP_INC || op_e == OP_DEC)) |=> $stable(flags_out[0])) else $error("inc/dec touched carry"); // R3
    AST_PARITY_LOW: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && d_wr && d_mask[2]) |=> (flags_out[2] == ~^res_out[7:0])) else $error("parity mismatch"); // R6
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && d_wr && d_mask[3]) |=> (flags_out[3] == (res_out == '0))) else $error("zero flag mismatch"); // R7
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && d_wr && !wide) |=> (res_out[DATA_W-1:HALF_W] == '0)) else $error("upper byte not clear"); // R8
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && d_unit == UNIT_LOGIC && d_lop != LG_NOT) |=> (!flags_out[0] && !flags_out[5] && !flags_out[1])) else $error("logic op left C/O/A"); // R9
    AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && (op_e == OP_CMP || op_e == OP_TEST)) |=> (!res_we && $stable(res_out))) else $error("compare wrote result"); // R10
    AST_ROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code >= 5'd16 && op_code <= 5'd19) |=> $stable(flags_out[4:1])) else $error("rotate changed PSZA"); // R12
    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_e == OP_STC) |=> flags_out[0]) else $error("STC failed"); // R13
    AST_CARRY_CLR: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_e == OP_CLC) |=> !flags_out[0]) else $error("CLC failed"); // R13
    AST_CARRY_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_e == OP_CMC) |=> (flags_out[0] != $past(flags_out[0]))) else $error("CMC failed"); // R13
    AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code > 5'd22) |=> ($stable(flags_out) && $stable(res_out) && !res_we)) else $error("undefined code acted"); // R14

endmodule

// File: tb/flg_alu_core_tb_top.sv
module flg_alu_core_tb_top;

    localparam int NV = 31;
    // {op[4:0], wide, a[15:0], b[15:0], exp_res[15:0], exp_we, exp_flags[5:0]}
    localparam logic [60:0] VEC [NV] = '{
        {5'd21, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 6'h00},
        {5'd0,  1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 6'h36},
        {5'd0,  1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 6'h0F},
        {5'd1,  1'b1, 16'h1234, 16'h1111, 16'h2346, 1'b1, 6'h00},
        {5'd2,  1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 6'h17},
        {5'd3,  1'b1, 16'h8000, 16'h0000, 16'h7FFF, 1'b1, 6'h26},
        {5'd7,  1'b1, 16'h0005, 16'h0005, 16'h7FFF, 1'b0, 6'h0C},
        {5'd8,  1'b1, 16'hF0F0, 16'hFF00, 16'hF000, 1'b1, 6'h14},
        {5'd9,  1'b0, 16'hAB01, 16'hCD80, 16'h0081, 1'b1, 6'h14},
        {5'd10, 1'b1, 16'h00FF, 16'h00FF, 16'h0000, 1'b1, 6'h0C},
        {5'd12, 1'b1, 16'h8001, 16'h8000, 16'h0000, 1'b0, 6'h14},
        {5'd11, 1'b1, 16'h00F0, 16'h0000, 16'hFF0F, 1'b1, 6'h14},
        {5'd20, 1'b1, 16'h0000, 16'h0000, 16'hFF0F, 1'b0, 6'h15},
        {5'd4,  1'b0, 16'h00FF, 16'h0000, 16'h0000, 1'b1, 6'h0F},
        {5'd5,  1'b0, 16'h0080, 16'h0000, 16'h007F, 1'b1, 6'h23},
        {5'd6,  1'b1, 16'h0001, 16'h0000, 16'hFFFF, 1'b1, 6'h17},
        {5'd6,  1'b1, 16'h8000, 16'h0000, 16'h8000, 1'b1, 6'h35},
        {5'd13, 1'b1, 16'h4001, 16'h0000, 16'h8002, 1'b1, 6'h30},
        {5'd14, 1'b0, 16'h0081, 16'h0000, 16'h0040, 1'b1, 6'h21},
        {5'd15, 1'b1, 16'h8003, 16'h0000, 16'hC001, 1'b1, 6'h11},
        {5'd15, 1'b0, 16'h0080, 16'h0000, 16'h00C0, 1'b1, 6'h14},
        {5'd16, 1'b1, 16'h8001, 16'h0000, 16'h0003, 1'b1, 6'h35},
        {5'd17, 1'b0, 16'h0002, 16'h0000, 16'h0001, 1'b1, 6'h14},
        {5'd18, 1'b1, 16'h8000, 16'h0000, 16'h0000, 1'b1, 6'h35},
        {5'd19, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b1, 6'h34},
        {5'd22, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b0, 6'h35},
        {5'd19, 1'b0, 16'h0002, 16'h0000, 16'h0081, 1'b1, 6'h34},
        {5'd31, 1'b1, 16'h1234, 16'h5678, 16'h0081, 1'b0, 6'h34},
        {5'd2,  1'b0, 16'h0010, 16'h0001, 16'h000F, 1'b1, 6'h06},
        {5'd0,  1'b0, 16'h0080, 16'h0080, 16'h0000, 1'b1, 6'h2D},
        {5'd0,  1'b0, 16'hAB12, 16'hCD34, 16'h0046, 1'b1, 6'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic        wide = 1'b1;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] res_out;
    logic        res_we;
    logic [5:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flg_alu_core #(.DATA_W(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .wide      (wide),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .res_out   (res_out),
        .res_we    (res_we),
        .flags_out (flags_out)
    );

    function automatic string req_of(input logic [4:0] op);
        if (op <= 5'd1 || op == 5'd4)        return "R3";
        if (op == 5'd7 || op == 5'd12)       return "R10";
        if (op <= 5'd6)                      return "R4";
        if (op <= 5'd11)                     return "R9";
        if (op <= 5'd15)                     return "R11";
        if (op <= 5'd19)                     return "R12";
        if (op <= 5'd22)                     return "R13";
        return "R14";
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "res_out at reset", res_out, 16'h0000);
        check("R1", "res_we at reset", {15'h0, res_we}, 16'h0000);
        check("R1", "flags at reset", {10'h0, flags_out}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [60:0] v;
            string       tg;
            v        = VEC[i];
            tg       = req_of(v[60:56]);
            op_code  = v[60:56];
            wide     = v[55];
            opnd_a   = v[54:39];
            opnd_b   = v[38:23];
            op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            opnd_a   = 16'hDEAD;
            opnd_b   = 16'hBEEF;
            check(tg, v[55] ? "result" : "result 8-bit R8", res_out, v[22:7]);
            check(tg, "write strobe R2", {15'h0, res_we}, {15'h0, v[6]});
            check(tg, "flags R5 R6 R7", {10'h0, flags_out}, {10'h0, v[5:0]});
            if (v[6]) begin
                @(negedge clk);
                check("R2", "strobe drops after one cycle", {15'h0, res_we}, 16'h0000);
            end
        end

        // R2: valid low with a carry-setting code applied must change nothing
        op_code = 5'd20;
        opnd_a  = 16'h5555;
        repeat (3) @(negedge clk);
        check("R2", "idle hold result", res_out, 16'h0046);
        check("R2", "idle hold flags", {10'h0, flags_out}, 16'h0000);
        check("R2", "idle strobe", {15'h0, res_we}, 16'h0000);

        // R13: STC followed by CMC twice returns carry to 1
        op_valid = 1'b1;
        @(negedge clk);
        op_code = 5'd22;
        @(negedge clk);
        check("R13", "CMC after STC", {10'h0, flags_out}, 16'h0000);
        @(negedge clk);
        op_valid = 1'b0;
        check("R13", "second CMC", {10'h0, flags_out}, 16'h0001);
        check("R13", "result untouched", res_out, 16'h0046);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "res_out after reset", res_out, 16'h0000);
        check("R1", "flags after reset", {10'h0, flags_out}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule